// File: doc/BRIEF.md
# Twisted-Pair Receive Line Status Monitor

This block sits after the line receiver and Manchester decoder of a 10BASE-T port. It keeps a read-only 16-bit status word that a host can sample at any time. The word shows whether the link is up, whether the incoming pair polarity is true, whether a frame is arriving, and which of the two physical ports is selected. The low six bits always hold a fixed identifier, so software can confirm which register it is reading.

The link is judged by a no-activity timer. Any activity strobe, from a link pulse or a received packet, marks the link up and restarts the timer. When the timer runs out, the link is marked down. The link also reads down from reset until the first activity is seen.

The block re-emits the recovered bit stream with the pair inversion corrected, unless correction is disabled. The polarity flag always shows the true incoming polarity. Carrier sense is taken from rising edges of the corrected stream and held for two bit times after the last one.

Both bit streams are valid-only. `rx_bit_stb` qualifies `rx_data`, and `corr_vld` qualifies `corr_data`. There is no ready signal in either direction: a line cannot be stalled, so the block accepts a bit on every strobe, and any consumer must take every output bit in the cycle it is valid.

Top module: `lsm_line_status`

## Requirements
- R1: During and straight after reset, `stat_word` reads 0x0014. Bits [5:0] always read 6'b010100, with bit 0 as the LSB. Bits 6, 10, 11, 13 and 15 always read 0.
- R2: The link-up flag in bit 7 is 0 after reset and stays 0 until `rx_act` is seen high, however long that takes.
- R3: `rx_act` high at a clock edge sets bit 7 after that edge. Bit 7 clears LINK_TMO cycles after the last edge at which `rx_act` was high. Every `rx_act` restarts this count.
- R4: Bit 12 shows `rx_pol_good` (1 = true polarity), registered once, whatever value `pol_fix_off` has.
- R5: For each cycle with `rx_bit_stb` high, `corr_vld` is high for one cycle after that edge. With `pol_fix_off` = 0, `corr_data` = `rx_data` XOR (NOT bit 12).
- R6: With `pol_fix_off` = 1, `corr_data` equals `rx_data` unchanged, even when bit 12 is 0.
- R7: Carrier sense in bit 14 sets after a strobe edge at which the corrected bit is 1 and the previous strobed corrected bit was 0. The previous bit is taken as 0 after reset.
- R8: Carrier sense clears exactly 2*CLK_PER_BIT cycles after the last such rising edge. A new rising edge restarts this hold.
- R9: One cycle after a change of `port_sel`, bit 8 is 1 when `port_sel` = 1 (AUI port in use). Bit 9 is 1 when `port_sel` = 0 (twisted-pair port in use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_act | input | 1 | Receive activity strobe (link pulse or packet) |
| rx_bit_stb | input | 1 | Bit-time strobe, valid for `rx_data` |
| rx_data | input | 1 | Recovered receive data bit |
| rx_pol_good | input | 1 | Raw polarity indication, 1 = true polarity |
| pol_fix_off | input | 1 | 1 disables automatic polarity correction |
| port_sel | input | 1 | 1 = AUI port, 0 = twisted-pair port |
| stat_word | output | 16 | Line status word |
| corr_vld | output | 1 | Valid for `corr_data` |
| corr_data | output | 1 | Polarity-corrected data bit |

## Verification
- **Flags with one cycle of latency.** Polarity, port and link-set results change one edge after the input. The bench samples them on the falling edge after that edge.
- **Link timeout.** The link drops at edge LINK_TMO after the activity edge. The bench counts edges from the activity pulse and checks one cycle before and at the drop.
- **Carrier hold.** Carrier sense holds for 2*CLK_PER_BIT edges from the last rising-edge strobe. The bench checks both sides of that boundary, once for a single rise and once where a later rise restarts the hold.
- **Corrected data.** Each corrected bit appears one edge after its strobe. The driver queues the value it expects, and a monitor pops and compares it whenever `corr_vld` is seen.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int BIT_LINK = 7;
  localparam int BIT_AUI  = 8;
  localparam int BIT_TP   = 9;
  localparam int BIT_POL  = 12;
  localparam int BIT_CRS  = 14;
  localparam int ID_W     = 6;
  localparam logic [ID_W-1:0] ID_CODE = 6'b010100;
  localparam int STAT_W   = 16;
endpackage

// File: rtl/lsm_link_timer.sv
module lsm_link_timer #(
  parameter int unsigned TMO_CYC = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic up_o
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (act_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        up_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign up_o = up_q;
endmodule

// File: rtl/lsm_pol_fix.sv
module lsm_pol_fix (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_good_i,
  input  logic fix_off_i,
  input  logic bit_stb_i,
  input  logic bit_i,
  output logic pol_true_o,
  output logic fix_bit_o,
  output logic out_vld_o,
  output logic out_bit_o
);
  logic pol_q;
  logic vld_q;
  logic bit_q;
  logic invert;

  assign invert    = ~pol_q & ~fix_off_i;
  assign fix_bit_o = bit_i ^ invert;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      pol_q <= pol_good_i;
      vld_q <= bit_stb_i;
      if (bit_stb_i) bit_q <= fix_bit_o;
    end
  end

  assign pol_true_o = pol_q;
  assign out_vld_o  = vld_q;
  assign out_bit_o  = bit_q;
endmodule

// File: rtl/lsm_carrier.sv
module lsm_carrier #(
  parameter int unsigned CLK_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb_i,
  input  logic bit_i,
  output logic crs_o
);
  localparam int unsigned HOLD = 2 * CLK_PER_BIT;
  localparam int unsigned HW   = $clog2(HOLD + 1);
  localparam logic [HW-1:0] RELOAD = HW'(HOLD - 1);

  logic          prev_q;
  logic          crs_q;
  logic [HW-1:0] hold_q;
  logic          rise;

  assign rise = bit_stb_i & bit_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      crs_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (bit_stb_i) prev_q <= bit_i;
      if (rise) begin
        crs_q  <= 1'b1;
        hold_q <= RELOAD;
      end else if (crs_q) begin
        if (hold_q == '0) crs_q <= 1'b0;
        else              hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign crs_o = crs_q;
endmodule

// File: rtl/lsm_line_status.sv
module lsm_line_status
  import lsm_pkg::*;
#(
  parameter int unsigned LINK_TMO    = 2000000,
  parameter int unsigned CLK_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_act,
  input  logic              rx_bit_stb,
  input  logic              rx_data,
  input  logic              rx_pol_good,
  input  logic              pol_fix_off,
  input  logic              port_sel,
  output logic [STAT_W-1:0] stat_word,
  output logic              corr_vld,
  output logic              corr_data
);
  logic lnk_up;
  logic pol_true;
  logic fix_bit;
  logic carrier;
  logic aui_q;
  logic tp_q;

  lsm_link_timer #(.TMO_CYC(LINK_TMO)) i_link (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (rx_act),
    .up_o  (lnk_up)
  );

  lsm_pol_fix i_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .pol_good_i (rx_pol_good),
    .fix_off_i  (pol_fix_off),
    .bit_stb_i  (rx_bit_stb),
    .bit_i      (rx_data),
    .pol_true_o (pol_true),
    .fix_bit_o  (fix_bit),
    .out_vld_o  (corr_vld),
    .out_bit_o  (corr_data)
  );

  lsm_carrier #(.CLK_PER_BIT(CLK_PER_BIT)) i_crs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (rx_bit_stb),
    .bit_i     (fix_bit),
    .crs_o     (carrier)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aui_q <= 1'b0;
      tp_q  <= 1'b0;
    end else begin
      aui_q <= port_sel;
      tp_q  <= ~port_sel;
    end
  end

  always_comb begin
    stat_word            = '0;
    stat_word[ID_W-1:0]  = ID_CODE;
    stat_word[BIT_LINK]  = lnk_up;
    stat_word[BIT_AUI]   = aui_q;
    stat_word[BIT_TP]    = tp_q;
    stat_word[BIT_POL]   = pol_true;
    stat_word[BIT_CRS]   = carrier;
  end
endmodule

// File: rtl/lsm_line_status_chk.sv
module lsm_line_status_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_act,
  input logic rx_bit_stb,
  input logic rx_data,
  input logic rx_pol_good,
  input logic pol_fix_off,
  input logic port_sel,
  input logic lnk,
  input logic aui,
  input logic pol,
  input logic crs,
  input logic corr_vld,
  input logic corr_data
);
  AST_LINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_act |=> lnk); // R3
  AST_LINK_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lnk) |-> !$past(rx_act)); // R3
  AST_POL_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pol == $past(rx_pol_good))); // R4
  AST_NO_FIX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit_stb && pol_fix_off) |=> (corr_vld && corr_data == $past(rx_data))); // R6
  AST_CRS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs) |-> $past(rx_bit_stb)); // R7
  AST_PORT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (aui == $past(port_sel))); // R9
endmodule

bind lsm_line_status lsm_line_status_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_act      (rx_act),
  .rx_bit_stb  (rx_bit_stb),
  .rx_data     (rx_data),
  .rx_pol_good (rx_pol_good),
  .pol_fix_off (pol_fix_off),
  .port_sel    (port_sel),
  .lnk         (stat_word[7]),
  .aui         (stat_word[8]),
  .pol         (stat_word[12]),
  .crs         (stat_word[14]),
  .corr_vld    (corr_vld),
  .corr_data   (corr_data)
);

// File: tb/test_lsm_line_status.sv
module test_lsm_line_status;
  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 40;
  localparam int CPB  = 4;
  localparam int HOLD = 2 * CPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_act = 1'b0;
  logic        rx_bit_stb = 1'b0;
  logic        rx_data = 1'b0;
  logic        rx_pol_good = 1'b1;
  logic        pol_fix_off = 1'b0;
  logic        port_sel = 1'b0;
  logic [15:0] stat_word;
  logic        corr_vld;
  logic        corr_data;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_line_status #(.LINK_TMO(TMO), .CLK_PER_BIT(CPB)) i_lsm_line_status (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .rx_bit_stb(rx_bit_stb),
    .rx_data(rx_data), .rx_pol_good(rx_pol_good), .pol_fix_off(pol_fix_off),
    .port_sel(port_sel), .stat_word(stat_word), .corr_vld(corr_vld),
    .corr_data(corr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, input string tag);
    repeat (CPB-1) @(posedge clk);
    #1;
    rx_data    = b;
    rx_bit_stb = 1'b1;
    exp_q.push_back(b ^ (!rx_pol_good && !pol_fix_off));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 rx_bit_stb = 1'b0;
  endtask

  task automatic pulse_act();
    @(posedge clk);
    #1 rx_act = 1'b1;
    @(posedge clk);
    #1 rx_act = 1'b0;
  endtask

  task automatic link_window(input string tag);
    @(negedge clk);
    chk(stat_word[7] == 1'b1, {tag, " set"}, 16'(stat_word[7]), 16'd1);
    repeat (TMO-1) @(posedge clk);
    @(negedge clk);
    chk(stat_word[7] == 1'b1, {tag, " held"}, 16'(stat_word[7]), 16'd1);
    @(posedge clk);
    @(negedge clk);
    chk(stat_word[7] == 1'b0, {tag, " timeout"}, 16'(stat_word[7]), 16'd0);
  endtask

  task automatic crs_window(input string tag);
    repeat (HOLD-1) @(posedge clk);
    @(negedge clk);
    chk(stat_word[14] == 1'b1, {tag, " held"}, 16'(stat_word[14]), 16'd1);
    @(posedge clk);
    @(negedge clk);
    chk(stat_word[14] == 1'b0, {tag, " release"}, 16'(stat_word[14]), 16'd0);
  endtask

  // monitor: compare corrected data with the queued expectation
  always @(negedge clk) begin
    if (rst_n && corr_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected corr_vld", 16'(corr_data), 16'd0);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(corr_data == e, t, 16'(corr_data), 16'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stat_word == 16'h0014, "R1 reset value", stat_word, 16'h0014);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(stat_word == 16'h0014, "R1 value after reset release", stat_word, 16'h0014);

    // R9 port select, R4 polarity flag, R1 id field and zero bits
    @(posedge clk);
    @(negedge clk);
    chk(stat_word == 16'h1214, "R9 twisted-pair port", stat_word, 16'h1214);
    @(posedge clk);
    #1 port_sel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(stat_word == 16'h1114, "R9 AUI port", stat_word, 16'h1114);

    // R2 link stays down with no activity
    repeat (3 * TMO) @(posedge clk);
    @(negedge clk);
    chk(stat_word[7] == 1'b0, "R2 link down before activity", 16'(stat_word[7]), 16'd0);

    // R3 set and timeout
    pulse_act();
    link_window("R3 single activity");
    // R3 restart
    pulse_act();
    repeat (TMO/2) @(posedge clk);
    pulse_act();
    link_window("R3 restarted timer");

    // R5 true polarity passes data
    send_bit(1'b1, "R5 true polarity bit");
    send_bit(1'b0, "R5 true polarity bit");
    send_bit(1'b1, "R5 true polarity bit");
    // R4 inverted polarity flagged, R5 corrected
    @(posedge clk);
    #1 rx_pol_good = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(stat_word[12] == 1'b0, "R4 inverted polarity shown", 16'(stat_word[12]), 16'd0);
    send_bit(1'b1, "R5 inverted corrected bit");
    send_bit(1'b0, "R5 inverted corrected bit");
    send_bit(1'b0, "R5 inverted corrected bit");
    // R6 correction disabled, R4 flag unchanged
    @(posedge clk);
    #1 pol_fix_off = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(stat_word[12] == 1'b0, "R4 flag true while correction off", 16'(stat_word[12]), 16'd0);
    send_bit(1'b1, "R6 uncorrected bit");
    send_bit(1'b0, "R6 uncorrected bit");
    @(posedge clk);
    #1;
    pol_fix_off = 1'b0;
    rx_pol_good = 1'b1;
    repeat (2 * HOLD) @(posedge clk);
    @(negedge clk);
    chk(stat_word[14] == 1'b0, "R8 carrier idle before frame", 16'(stat_word[14]), 16'd0);

    // R7 / R8 single rising edge
    send_bit(1'b0, "R5 carrier lead bit");
    send_bit(1'b1, "R5 carrier rise bit");
    @(negedge clk);
    chk(stat_word[14] == 1'b1, "R7 carrier on rising edge", 16'(stat_word[14]), 16'd1);
    crs_window("R8 single rise");

    // R8 later rising edge restarts the hold
    send_bit(1'b0, "R5 carrier bit");
    send_bit(1'b1, "R5 carrier bit");
    send_bit(1'b0, "R5 carrier bit");
    send_bit(1'b1, "R5 carrier bit");
    @(negedge clk);
    chk(stat_word[14] == 1'b1, "R7 carrier on second rise", 16'(stat_word[14]), 16'd1);
    crs_window("R8 restarted hold");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all corrected bits seen", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule